// File: doc/BRIEF.md
# Majority-Clocked Triple-LFSR Keystream Generator

This block produces one frame of keystream for a stream cipher of the mobile-telephony family. Three linear feedback shift registers of lengths 19, 22 and 23 are built from a 64-bit session key and a 22-bit frame number. A one-cycle `start` pulse clears them. The key and then the frame number are folded in serially, one bit per cycle, and every register steps on each of these cycles. After loading, the registers move under a stop/go majority rule. The output is discarded for 100 mixing cycles. Then one keystream bit per cycle is presented with a valid flag for 228 cycles, and `done` is raised.

The controller is a single state machine with six states. IDLE waits for start. LOAD_KEY covers 64 cycles of key injection. LOAD_FRAME covers 22 cycles of frame-number injection. MIX covers 100 majority-clocked cycles with no output. EMIT covers 228 majority-clocked cycles of output. FINISHED holds `done`. The transitions are as follows. IDLE or FINISHED goes to LOAD_KEY on start. LOAD_KEY goes to LOAD_FRAME after its 64th cycle. LOAD_FRAME goes to MIX after its 22nd cycle. MIX goes to EMIT after its 100th cycle. EMIT goes to FINISHED after its 228th cycle.

Top module: `mvote_keystream`

## Requirements
- R1: Out of reset, `ks_valid`, `done` and `ks_bit` are all 0.
- R2: A `start` pulse seen in IDLE or FINISHED clears all three registers to zero and enters LOAD_KEY. A `start` seen in any other state is ignored, and the stream and its timing are unchanged.
- R3: In LOAD_KEY, for cycle i (0 to 63), every register shifts one place toward its MSB. Its new bit 0 is its feedback XOR `key[i]`. No stop/go rule applies.
- R4: In LOAD_FRAME, for cycle i (0 to 21), the same happens with `frame_no[i]`, again with every register stepping.
- R5: The registers are 19, 22 and 23 bits long. Their feedback is the XOR of bits {18,17,16,13}, {21,20} and {22,21,20,7} respectively.
- R6: In MIX and EMIT, the clocking bits are bits 8, 10 and 10 of the three registers. A register steps (with no injection) only when its clocking bit equals the majority of the three.
- R7: MIX lasts 100 cycles with `ks_valid` low. The first valid bit appears in the 187th cycle after the edge that accepts `start`.
- R8: `ks_valid` is high for exactly 228 consecutive cycles. In each of them, `ks_bit` is the XOR of the three register MSBs before that cycle's step.
- R9: `done` rises the cycle after the last valid bit and stays high until the next accepted `start`. `done` and `ks_valid` are never high together, and `ks_bit` is 0 whenever `ks_valid` is low.
- R10: A `start` while `done` is high begins a new frame, whose stream depends only on the new key and frame number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| key | input | 64 | Session key, bit 0 injected first |
| frame_no | input | 22 | Frame number, bit 0 injected first |
| ks_bit | output | 1 | Keystream bit, 0 when not valid |
| ks_valid | output | 1 | High while `ks_bit` carries keystream |
| done | output | 1 | High from the end of a frame until the next start |

## Verification
The checker assumes that `start` is a pulse and that `key` and `frame_no` do not change between an accepted start and the end of the frame. The stimulus changes them only while the block is idle or finished. Its properties watch the run length of `ks_valid`, the exclusion between `done` and `ks_valid`, and the holding of `done`. These properties do not depend on key values. The stimulus includes a stray `start` during loading, so the claim that such a start is ignored is exercised rather than assumed.

// File: rtl/mvk_pkg.sv
package mvk_pkg;
    localparam int KEY_W   = 64;
    localparam int FRAME_W = 22;
    localparam int MIX_CYC = 100;
    localparam int KS_LEN  = 228;

    localparam int LEN_A = 19;
    localparam int LEN_B = 22;
    localparam int LEN_C = 23;

    localparam logic [LEN_A-1:0] TAP_A = LEN_A'((1 << 18) | (1 << 17) | (1 << 16) | (1 << 13));
    localparam logic [LEN_B-1:0] TAP_B = LEN_B'((1 << 21) | (1 << 20));
    localparam logic [LEN_C-1:0] TAP_C = LEN_C'((1 << 22) | (1 << 21) | (1 << 20) | (1 << 7));

    localparam int CK_A = 8;
    localparam int CK_B = 10;
    localparam int CK_C = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_KEY,
        ST_LOAD_FRAME,
        ST_MIX,
        ST_EMIT,
        ST_FINISHED
    } kstate_t;
endpackage

// File: rtl/mvk_shift_reg.sv
module mvk_shift_reg #(
    parameter int               LEN   = 19,
    parameter logic [LEN-1:0]   TAPS  = '0,
    parameter int               CKPOS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic inject,
    output logic ck_bit,
    output logic msb
);
    logic [LEN-1:0] r_q;
    logic           fb;

    // R5: feedback is the parity of the tapped bits
    assign fb = (^(r_q & TAPS)) ^ inject;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      r_q <= '0;
        else if (clear)  r_q <= '0;
        else if (step)   r_q <= {r_q[LEN-2:0], fb};
    end

    assign ck_bit = r_q[CKPOS];
    assign msb    = r_q[LEN-1];
endmodule

// File: rtl/mvk_majority.sv
module mvk_majority (
    input  logic [2:0] ck,
    output logic [2:0] go
);
    logic maj;
    assign maj = (ck[0] & ck[1]) | (ck[0] & ck[2]) | (ck[1] & ck[2]);

    // R6: a register moves only when it agrees with the vote
    for (genvar g = 0; g < 3; g++) begin : g_vote
        assign go[g] = (ck[g] == maj);
    end
endmodule

// File: rtl/mvote_keystream.sv
module mvote_keystream
    import mvk_pkg::*;
#(
    parameter int P_KEY_W   = KEY_W,
    parameter int P_FRAME_W = FRAME_W,
    parameter int P_MIX_CYC = MIX_CYC,
    parameter int P_KS_LEN  = KS_LEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [P_KEY_W-1:0]   key,
    input  logic [P_FRAME_W-1:0] frame_no,
    output logic                 ks_bit,
    output logic                 ks_valid,
    output logic                 done
);
    localparam int M1  = (P_KEY_W > P_FRAME_W) ? P_KEY_W : P_FRAME_W;
    localparam int M2  = (P_MIX_CYC > P_KS_LEN) ? P_MIX_CYC : P_KS_LEN;
    localparam int MX  = (M1 > M2) ? M1 : M2;
    localparam int CW  = $clog2(MX + 1);
    localparam int KIW = $clog2(P_KEY_W);
    localparam int FIW = $clog2(P_FRAME_W);

    kstate_t       state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          accept, last, inj;
    logic [2:0]    ck, go, step, msb;

    assign accept = start && (state_q == ST_IDLE || state_q == ST_FINISHED);

    // phase length test for the current state
    always_comb begin
        unique case (state_q)
            ST_LOAD_KEY:   last = (cnt_q == CW'(P_KEY_W - 1));
            ST_LOAD_FRAME: last = (cnt_q == CW'(P_FRAME_W - 1));
            ST_MIX:        last = (cnt_q == CW'(P_MIX_CYC - 1));
            ST_EMIT:       last = (cnt_q == CW'(P_KS_LEN - 1));
            default:       last = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISHED: if (accept) state_d = ST_LOAD_KEY;
            ST_LOAD_KEY:          if (last)   state_d = ST_LOAD_FRAME;
            ST_LOAD_FRAME:        if (last)   state_d = ST_MIX;
            ST_MIX:               if (last)   state_d = ST_EMIT;
            ST_EMIT:              if (last)   state_d = ST_FINISHED;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
        end
    end

    // R3/R4 injection bit and step control
    always_comb begin
        inj  = 1'b0;
        step = 3'b000;
        unique case (state_q)
            ST_LOAD_KEY: begin
                inj  = key[cnt_q[KIW-1:0]];
                step = 3'b111;
            end
            ST_LOAD_FRAME: begin
                inj  = frame_no[cnt_q[FIW-1:0]];
                step = 3'b111;
            end
            ST_MIX, ST_EMIT: step = go;
            default: step = 3'b000;
        endcase
    end

    mvk_shift_reg #(.LEN(LEN_A), .TAPS(TAP_A), .CKPOS(CK_A)) u_ra (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(step[0]),
        .inject(inj), .ck_bit(ck[0]), .msb(msb[0]));
    mvk_shift_reg #(.LEN(LEN_B), .TAPS(TAP_B), .CKPOS(CK_B)) u_rb (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(step[1]),
        .inject(inj), .ck_bit(ck[1]), .msb(msb[1]));
    mvk_shift_reg #(.LEN(LEN_C), .TAPS(TAP_C), .CKPOS(CK_C)) u_rc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(step[2]),
        .inject(inj), .ck_bit(ck[2]), .msb(msb[2]));

    mvk_majority u_vote (.ck(ck), .go(go));

    // outputs
    always_comb begin
        ks_valid = (state_q == ST_EMIT);
        done     = (state_q == ST_FINISHED);
        ks_bit   = ks_valid ? ^msb : 1'b0;
    end
endmodule

// File: rtl/mvk_checker.sv
module mvk_checker #(
    parameter int P_KS_LEN = 228
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ks_bit,
    input logic ks_valid,
    input logic done
);
    localparam int RW = $clog2(P_KS_LEN + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= '0;
        else if (ks_valid) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    p_run_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> (run_q < RW'(P_KS_LEN)));

    p_run_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ks_valid) |-> (run_q == RW'(P_KS_LEN)));

    p_done_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ks_valid) |-> done);

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ks_valid && done));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_quiet_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ks_valid |-> !ks_bit);
endmodule

bind mvote_keystream mvk_checker #(.P_KS_LEN(P_KS_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ks_bit(ks_bit),
    .ks_valid(ks_valid), .done(done));

// File: tb/mvote_keystream_test.sv
module mvote_keystream_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] key = '0;
    logic [21:0] frame_no = '0;
    logic        ks_bit, ks_valid, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    mvote_keystream uut (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key),
        .frame_no(frame_no), .ks_bit(ks_bit), .ks_valid(ks_valid), .done(done));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // independent reference built from R3..R8
    function automatic logic [227:0] ref_stream(input logic [63:0] k, input logic [21:0] f);
        logic [18:0] a = '0;
        logic [21:0] b = '0;
        logic [22:0] c = '0;
        logic [227:0] o = '0;
        logic m;
        for (int i = 0; i < 64; i++) begin
            a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13] ^ k[i]};
            b = {b[20:0], b[21] ^ b[20] ^ k[i]};
            c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7] ^ k[i]};
        end
        for (int i = 0; i < 22; i++) begin
            a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13] ^ f[i]};
            b = {b[20:0], b[21] ^ b[20] ^ f[i]};
            c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7] ^ f[i]};
        end
        for (int i = 0; i < 328; i++) begin
            if (i >= 100) o[i-100] = a[18] ^ b[21] ^ c[22];
            m = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
            if (a[8] == m)  a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
            if (b[10] == m) b = {b[20:0], b[21] ^ b[20]};
            if (c[10] == m) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
        end
        return o;
    endfunction

    // runs a frame; poke_at >= 0 pulses start again inside the preamble
    task automatic run_frame(input logic [63:0] k, input logic [21:0] f,
                             input int poke_at, input string tag);
        logic [227:0] exp_s;
        int early_valid, bad_bits, valid_cnt;
        exp_s = ref_stream(k, f);
        key = k; frame_no = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        early_valid = 0;
        for (int j = 0; j < 186; j++) begin
            if (ks_valid || ks_bit) early_valid++;
            start = (j == poke_at);
            @(negedge clk);
        end
        start = 1'b0;
        chk({tag, " R7 valid low through load and mix"}, early_valid, 0);
        bad_bits = 0; valid_cnt = 0;
        for (int j = 0; j < 228; j++) begin
            if (ks_valid) valid_cnt++;
            if (ks_bit !== exp_s[j]) begin
                bad_bits++;
                if (bad_bits == 1)
                    $display("FAIL %s R8 bit %0d actual=%0b expected=%0b", tag, j, ks_bit, exp_s[j]);
            end
            @(negedge clk);
        end
        n_checks++;
        if (bad_bits != 0) n_fail++;
        chk({tag, " R8 valid count"}, valid_cnt, 228);
        chk({tag, " R9 done after stream"}, {ks_valid, done}, 2'b01);
        chk({tag, " R9 ks_bit quiet"}, ks_bit, 0);
    endtask

    task automatic t_reset_state();
        chk("R1 reset outputs", {ks_bit, ks_valid, done}, 3'b000);
    endtask

    task automatic t_done_holds();
        repeat (20) @(negedge clk);
        chk("R9 done holds without start", {ks_valid, done}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        run_frame(64'h0123_4567_89AB_CDEF, 22'h000134, -1, "R3 R4 R5 R6 mixed");
        t_done_holds();
        run_frame(64'h0, 22'h0, -1, "R2 zero key");
        run_frame(64'hFFFF_FFFF_FFFF_FFFF, 22'h3FFFFF, -1, "R10 restart all ones");
        run_frame(64'h8000_0000_0000_0001, 22'h200001, 30, "R2 stray start in key load");
        run_frame(64'h5A5A_C3C3_0F0F_9696, 22'h15A5A5, 120, "R2 stray start in mix");
        t_done_holds();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule